// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

This block is one bank of 32 general-purpose I/O pins with interrupt detection on every pin. Software reads and writes it through a small 32-bit register bus. Each pin has an output value, a drive enable and an input sample taken through a two-flop synchronizer. When a pin's drive enable is 1, the pin drives its output value; when it is 0, the pin is an input.

Every pin can raise an interrupt on a rising edge, a falling edge, a high level or a low level. Two separate per-pin bits choose the trigger: one selects edge or level mode, the other selects the sense. A detected event is latched into a per-pin status bit. The block drives one interrupt line for the whole bank.

Each register has three write forms:
- a plain write, which replaces the register;
- a set alias, which ORs in the 1 bits written;
- a clear alias, which clears the bits written as 1.

Status bits can only be removed through the clear alias of the status register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0 and `irq` is 0.
- R2: Register groups use byte offsets:

  | Offset | Register |
  |---|---|
  | 0x00 | output value |
  | 0x10 | input sample |
  | 0x20 | drive enable |
  | 0x30 | routing |
  | 0x40 | interrupt enable |
  | 0x50 | mode (1 = level, 0 = edge) |
  | 0x60 | sense (1 = high/rising, 0 = low/falling) |
  | 0x70 | status |

  Address bits [3:2] pick the access form: 0 is a plain write, 1 ORs in the written 1s, 2 clears the bits written as 1, and 3 writes nothing. A read at any of the four forms returns the register. Reads at 0x80 and above return 0. The bus carries a word address, `reg_addr` = byte offset >> 2.
- R3: `pin_out` equals the output value register and `pin_oe` equals the drive enable register, from the clock edge that writes them.
- R4: The input sample register returns `pin_in` delayed by two clock edges (a two-flop synchronizer).
- R5: In edge mode with sense 1, a 0-to-1 change of the synchronized input sets the status bit. The bit is set on the third rising clock edge after `pin_in` changes. A steady high level sets nothing more.
- R6: In edge mode with sense 0, a 1-to-0 change of the synchronized input sets the status bit, with the same latency as R5.
- R7: In level mode the status bit is set on every clock while the synchronized input is at the active level (1 for sense 1, 0 for sense 0). A clear-alias write to such a bit wins for that one edge, so the bit reads 0 for one cycle and is set again on the next edge if the level persists.
- R8: A status bit is set only when both its routing bit and its interrupt-enable bit are 1.
- R9: Status bits stay set until cleared through the status clear alias. Plain and set-alias writes to the status register, and any write to the input sample register, have no effect.
- R10: `irq` is 1 exactly when some pin has both its status bit and its interrupt-enable bit at 1. Clearing an enable bit hides that pin's status from `irq` without clearing the status.
- R11: In edge mode, a new edge detected on the same clock edge as a clear-alias write to that bit leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Word address, byte offset bits [7:2] |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin drive enables |
| irq | output | 1 | Combined bank interrupt |

## Verification
The following faults show at the ports, and how soon:

| Fault | Where it shows | When |
|---|---|---|
| Corrupt control bit | Register read-back, `pin_out` or `pin_oe` | The cycle after the write that set it |
| Synchronizer stage missing or extra | Input sample read | One cycle early or late, against the fixed two-edge latency |
| Stale or wrong edge history | Spurious or missing status bits | On the third edge after a pin change |
| Wrong status priority | Status read | One cycle after a clear write, either in the level-mode re-arm or in the same-edge clear of R11 |

A bank-wide error in the enable or status logic appears on `irq` in the same cycle as the status read, so the cycle-by-cycle comparison catches it at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register group codes (byte offset bits [7:4]).
  localparam int unsigned GRP_DOUT  = 0;
  localparam int unsigned GRP_DIN   = 1;
  localparam int unsigned GRP_DOE   = 2;
  localparam int unsigned GRP_ROUTE = 3;
  localparam int unsigned GRP_IEN   = 4;
  localparam int unsigned GRP_LVL   = 5;
  localparam int unsigned GRP_POL   = 6;
  localparam int unsigned GRP_STAT  = 7;

  // Access forms (byte offset bits [3:2]); code 3 writes nothing.
  localparam logic [1:0] AL_PLAIN = 2'd0;
  localparam logic [1:0] AL_SET   = 2'd1;
  localparam logic [1:0] AL_CLR   = 2'd2;

  // Number of plain read/write control registers.
  localparam int NCTL = 6;

  // Control register index -> group code.
  function automatic int unsigned ctl_group(input int k);
    case (k)
      0:       return GRP_DOUT;
      1:       return GRP_DOE;
      2:       return GRP_ROUTE;
      3:       return GRP_IEN;
      4:       return GRP_LVL;
      default: return GRP_POL;
    endcase
  endfunction

  // New value of one register bit under a given access form.
  function automatic logic alias_bit(input logic old_v, input logic wr_v,
                                     input logic [1:0] form);
    case (form)
      AL_PLAIN: return wr_v;
      AL_SET:   return old_v | wr_v;
      AL_CLR:   return old_v & ~wr_v;
      default:  return old_v;
    endcase
  endfunction

  // Trigger condition for one pin.
  // lvl = 1 selects level mode, pol = 1 selects high/rising.
  function automatic logic trig_bit(input logic lvl, input logic pol,
                                    input logic cur, input logic prv);
    if (lvl) return pol ? cur : ~cur;
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // Next status bit.
  // Level mode: the clear wins for this edge.
  // Edge mode: a new event wins over the clear.
  function automatic logic stat_bit(input logic lvl, input logic cur_stat,
                                    input logic hit, input logic clr);
    if (lvl) return (cur_stat | hit) & ~clr;
    return (cur_stat & ~clr) | hit;
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_q,
  output logic [NPINS-1:0] prev_q
);

  logic [NPINS-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      prev_q <= '0;
    end else begin
      pipe[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev_q <= pipe[STAGES-1];
    end
  end

  assign sync_q = pipe[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:2]    reg_addr,
  input  logic             reg_wr,
  input  logic [NPINS-1:0] reg_wdata,
  input  logic [NPINS-1:0] din_sync,
  input  logic [NPINS-1:0] stat_q,
  output logic [NPINS-1:0] reg_rdata,
  output logic [NPINS-1:0] dout_q,
  output logic [NPINS-1:0] doe_q,
  output logic [NPINS-1:0] route_q,
  output logic [NPINS-1:0] ien_q,
  output logic [NPINS-1:0] lvl_q,
  output logic [NPINS-1:0] pol_q,
  output logic [NPINS-1:0] clr_mask
);

  localparam int GW = AW - 4;

  logic [GW-1:0]    grp;
  logic [1:0]       form;
  logic [NPINS-1:0] ctl_vec [NCTL];

  assign grp  = reg_addr[AW-1:4];
  assign form = reg_addr[3:2];

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    logic             sel;
    logic [NPINS-1:0] q;

    assign sel = reg_wr && (grp == GW'(ctl_group(k)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sel) begin
        for (int i = 0; i < NPINS; i++) q[i] <= alias_bit(q[i], reg_wdata[i], form);
      end
    end

    assign ctl_vec[k] = q;
  end

  assign dout_q  = ctl_vec[0];
  assign doe_q   = ctl_vec[1];
  assign route_q = ctl_vec[2];
  assign ien_q   = ctl_vec[3];
  assign lvl_q   = ctl_vec[4];
  assign pol_q   = ctl_vec[5];

  // Status can only lose bits through its clear alias.
  assign clr_mask = (reg_wr && grp == GW'(GRP_STAT) && form == AL_CLR) ? reg_wdata : '0;

  always_comb begin
    reg_rdata = '0;
    if (grp == GW'(GRP_DIN)) begin
      reg_rdata = din_sync;
    end else if (grp == GW'(GRP_STAT)) begin
      reg_rdata = stat_q;
    end else begin
      for (int k = 0; k < NCTL; k++) begin
        if (grp == GW'(ctl_group(k))) reg_rdata = ctl_vec[k];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sync_q,
  input  logic [NPINS-1:0] prev_q,
  input  logic [NPINS-1:0] lvl_q,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] route_q,
  input  logic [NPINS-1:0] ien_q,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] stat_q,
  output logic             irq
);

  logic [NPINS-1:0] stat_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i]    = trig_bit(lvl_q[i], pol_q[i], sync_q[i], prev_q[i])
                       & route_q[i] & ien_q[i];
    assign stat_d[i] = stat_bit(lvl_q[i], stat_q[i], hit[i], clr_mask[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign irq = |(stat_q & ien_q);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:2]    reg_addr,
  input  logic             reg_wr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);

  logic [NPINS-1:0] din_sync;
  logic [NPINS-1:0] prev_sync;
  logic [NPINS-1:0] stat_q;
  logic [NPINS-1:0] route_q;
  logic [NPINS-1:0] ien_q;
  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] hit;

  gpio_sync_edge #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sync_q (din_sync),
    .prev_q (prev_sync)
  );

  gpio_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .din_sync  (din_sync),
    .stat_q    (stat_q),
    .reg_rdata (reg_rdata),
    .dout_q    (pin_out),
    .doe_q     (pin_oe),
    .route_q   (route_q),
    .ien_q     (ien_q),
    .lvl_q     (lvl_q),
    .pol_q     (pol_q),
    .clr_mask  (clr_mask)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_q   (din_sync),
    .prev_q   (prev_sync),
    .lvl_q    (lvl_q),
    .pol_q    (pol_q),
    .route_q  (route_q),
    .ien_q    (ien_q),
    .clr_mask (clr_mask),
    .hit      (hit),
    .stat_q   (stat_q),
    .irq      (irq)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:2]    reg_addr,
  input logic             reg_wr,
  input logic [NPINS-1:0] reg_wdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] route_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] clr_mask,
  input logic [NPINS-1:0] din_sync
);

  // Clock edges since reset release, saturating at 2.
  logic [1:0] warm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_cnt <= 2'd0;
    else if (warm_cnt != 2) warm_cnt <= warm_cnt + 2'd1;
  end

  // R1: quiet outputs while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!irq && pin_oe == '0 && stat_q == '0)
        else $error("reset state not idle");
    end
  end

  // R2: a clear-alias write to the output register removes the written bits.
  p_alias_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[AW-1:4] == '0 && reg_addr[3:2] == 2'd2)
      |=> ((pin_out & $past(reg_wdata)) == '0));

  // R4: the input sample lags the pin by two edges.
  p_sync_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 2'd2) |-> (din_sync == $past(pin_in, 2)));

  // R8: a newly set status bit had routing and enable both at 1.
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~($past(route_q) & $past(ien_q))) == '0));

  // R9: a status bit only drops when its clear mask bit was 1.
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_mask) & ~stat_q) == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_q    (stat_q),
  .route_q   (route_q),
  .ien_q     (ien_q),
  .clr_mask  (clr_mask),
  .din_sync  (din_sync)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:2]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(32), .AW(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_dout, m_doe, m_route, m_ien, m_lvl, m_pol, m_stat;
  logic [31:0] m_s1, m_s2, m_prev;

  function automatic logic [31:0] m_apply(input logic [31:0] old_v,
                                          input logic [31:0] w,
                                          input int form);
    if (form == 0) return w;
    if (form == 1) return old_v | w;
    if (form == 2) return old_v & ~w;
    return old_v;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:2] wa);
    int g;
    g = int'(wa[7:4]);
    case (g)
      0: return m_dout;
      1: return m_s2;
      2: return m_doe;
      3: return m_route;
      4: return m_ien;
      5: return m_lvl;
      6: return m_pol;
      7: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = '0; m_doe = '0; m_route = '0; m_ien = '0;
      m_lvl = '0; m_pol = '0; m_stat = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      logic [31:0] ev;
      logic [31:0] cm;
      logic [31:0] ns;
      int g;
      int f;
      g = int'(reg_addr[7:4]);
      f = int'(reg_addr[3:2]);

      for (int i = 0; i < 32; i++) begin
        bit t;
        case ({m_lvl[i], m_pol[i]})
          2'b01:   t = m_s2[i] && !m_prev[i];
          2'b00:   t = !m_s2[i] && m_prev[i];
          2'b11:   t = m_s2[i];
          default: t = !m_s2[i];
        endcase
        ev[i] = t && m_route[i] && m_ien[i];
      end

      cm = (reg_wr && g == 7 && f == 2) ? reg_wdata : 32'h0;

      for (int i = 0; i < 32; i++) begin
        if (m_lvl[i]) ns[i] = (m_stat[i] || ev[i]) && !cm[i];
        else          ns[i] = (m_stat[i] && !cm[i]) || ev[i];
      end

      if (reg_wr && f != 3) begin
        case (g)
          0: m_dout  = m_apply(m_dout,  reg_wdata, f);
          2: m_doe   = m_apply(m_doe,   reg_wdata, f);
          3: m_route = m_apply(m_route, reg_wdata, f);
          4: m_ien   = m_apply(m_ien,   reg_wdata, f);
          5: m_lvl   = m_apply(m_lvl,   reg_wdata, f);
          6: m_pol   = m_apply(m_pol,   reg_wdata, f);
          default: ;
        endcase
      end

      m_stat = ns;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison of every output against the model.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R3 pin_out model", pin_out, m_dout);
      check("R3 pin_oe model", pin_oe, m_doe);
      check("R10 irq model", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
      check("R2 rdata model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a[7:2];
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd_now(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a[7:2];
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_set(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    for (int g = 0; g < 8; g++) begin
      rd_now(8'(g * 16), 32'h0, "R1 reset reg");
    end
    check("R1 pin_oe reset", pin_oe, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 and R3: access forms on the output register
    wr(8'h00, 32'hA5A5_0F0F);
    rd_now(8'h00, 32'hA5A5_0F0F, "R2 plain write");
    wr(8'h04, 32'h0000_F000);
    rd_now(8'h00, 32'hA5A5_FF0F, "R2 set alias");
    wr(8'h08, 32'hA500_0000);
    rd_now(8'h00, 32'h00A5_FF0F, "R2 clr alias");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_now(8'h04, 32'h00A5_FF0F, "R2 form 3 ignored, read at alias");
    rd_now(8'h80, 32'h0, "R2 unmapped read");
    check("R3 pin_out", pin_out, 32'h00A5_FF0F);
    wr(8'h20, 32'hFFFF_0000);
    check("R3 pin_oe", pin_oe, 32'hFFFF_0000);

    // R4: two-edge input latency
    pin_set(32'h1234_5678);
    step(1);
    rd_now(8'h10, 32'h0, "R4 not yet visible");
    step(1);
    rd_now(8'h10, 32'h1234_5678, "R4 visible after two edges");

    // R9: writes to the input sample register are ignored
    wr(8'h10, 32'hFFFF_FFFF);
    rd_now(8'h10, 32'h1234_5678, "R9 din write ignored");

    // Pin trigger setup:
    //   pin0 rising, pin1 falling, pin2 high level, pin3 low level
    //   pin4 routed only, pin5 enabled only
    pin_set(32'h0000_0008);
    step(4);
    wr(8'h60, 32'h0000_0035);
    wr(8'h50, 32'h0000_000C);
    wr(8'h30, 32'h0000_001F);
    wr(8'h40, 32'h0000_002F);
    wr(8'h78, 32'hFFFF_FFFF);
    rd_now(8'h70, 32'h0, "R7 no level event at idle");

    // R5: rising edge
    pin_set(32'h0000_0009);
    step(2);
    rd_now(8'h70, 32'h0, "R5 not yet set");
    step(1);
    rd_now(8'h70, 32'h1, "R5 rising set");
    check("R10 irq on", {31'b0, irq}, 32'h1);
    wr(8'h70, 32'h0);
    wr(8'h74, 32'h2);
    rd_now(8'h70, 32'h1, "R9 plain/set ignored on status");
    wr(8'h78, 32'h1);
    rd_now(8'h70, 32'h0, "R9 clear alias");
    step(2);
    rd_now(8'h70, 32'h0, "R5 steady high no retrigger");

    // R6: falling edge
    pin_set(32'h0000_000B);
    step(4);
    rd_now(8'h70, 32'h0, "R6 rise ignored");
    pin_set(32'h0000_0009);
    step(3);
    rd_now(8'h70, 32'h2, "R6 falling set");
    wr(8'h78, 32'h2);
    rd_now(8'h70, 32'h0, "R6 cleared");

    // R8: gating
    pin_set(32'h0000_0039);
    step(4);
    rd_now(8'h70, 32'h0, "R8 route-only and enable-only pins");
    check("R8 irq stays low", {31'b0, irq}, 32'h0);

    // R7: high level, clear then re-arm
    pin_set(32'h0000_003D);
    step(3);
    rd_now(8'h70, 32'h4, "R7 high level set");
    wr(8'h78, 32'h4);
    rd_now(8'h70, 32'h0, "R7 clear wins one cycle");
    step(1);
    rd_now(8'h70, 32'h4, "R7 rearm");
    pin_set(32'h0000_0039);
    step(3);
    rd_now(8'h70, 32'h4, "R9 sticky after level drop");
    wr(8'h78, 32'h4);
    rd_now(8'h70, 32'h0, "R7 cleared after drop");
    step(1);
    rd_now(8'h70, 32'h0, "R7 stays clear");

    // R7: low level
    pin_set(32'h0000_0031);
    step(3);
    rd_now(8'h70, 32'h8, "R7 low level set");
    pin_set(32'h0000_0039);
    step(3);
    wr(8'h78, 32'h8);
    rd_now(8'h70, 32'h0, "R7 low cleared");

    // R10: masking hides status from irq
    pin_set(32'h0000_0038);
    step(3);
    pin_set(32'h0000_0039);
    step(3);
    rd_now(8'h70, 32'h1, "R10 pending");
    wr(8'h48, 32'h1);
    rd_now(8'h70, 32'h1, "R10 status kept when masked");
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h44, 32'h1);
    check("R10 irq unmasked", {31'b0, irq}, 32'h1);
    wr(8'h78, 32'h1);

    // R11: new edge on the clearing edge
    pin_set(32'h0000_0038);
    step(3);
    pin_set(32'h0000_0039);
    step(3);
    rd_now(8'h70, 32'h1, "R11 first event");
    pin_set(32'h0000_0038);
    step(3);
    pin_set(32'h0000_0039);
    step(1);
    wr(8'h78, 32'h1);
    rd_now(8'h70, 32'h1, "R11 event beats clear");
    wr(8'h78, 32'h1);
    rd_now(8'h70, 32'h0, "R11 later clear");

    step(2);
    finish_run();
  end

endmodule